// File: doc/BRIEF.md
# RMII Transmit Dibit Serializer

This block sits on the MAC side of a reduced media-independent interface running at 100 Mbps. It takes frame bytes from an upstream source over a valid/ready handshake, with a marker on the first byte and another on the final byte. For each frame it first sends the preamble and the start-of-frame delimiter. It then sends the payload, two bits per reference clock, on the transmit enable and transmit data pins. The payload must already carry its frame check sequence. The block neither computes a CRC nor handles collisions.

A frame starts when a byte flagged as first is offered while the block is idle and the inter-frame gap has run out. The first byte is held by the source and is taken only when the preamble finishes. After that the block asks for one byte every four clock cycles. If the source has nothing ready when asked, the frame ends after the byte already on the wire. Between frames the transmit pins stay quiet for at least 48 clock cycles.

Top module: `rmii_tx_serializer`

## Requirements
- R1: During reset and right after it, tx_en is 0, txd is 00 and in_ready is 0 while no byte is offered.
- R2: Whenever tx_en is 0, txd is 00.
- R3: When a byte with in_first set is offered to an idle block and the gap has expired, tx_en rises at the next clock edge, together with the first preamble dibit 01.
- R4: The preamble is 32 dibits. The first 31 are 01 (seven 0x55 bytes plus the low three pairs of 0xD5), and the 32nd is 11, ending the 0xD5 delimiter.
- R5: Each payload byte goes out as four consecutive dibits in the order bits[1:0], [3:2], [5:4], [7:6].
- R6: In_ready is high during a frame only in the last dibit cycle of the preamble and in the last dibit cycle of each byte that is not marked last. A byte is taken at the clock edge where in_valid and in_ready are both high.
- R7: tx_en stays high without a break from the first preamble dibit to the last dibit of the byte marked last, and falls at the next edge. A frame is therefore 32 + 4·N cycles long.
- R8: If in_valid is low when in_ready is high in a frame, the frame ends after the byte currently being sent, and no further byte is taken.
- R9: tx_en stays low for at least 48 cycles between frames. A frame that is already waiting starts after exactly 48 low cycles.
- R10: While no frame is being sent, a byte offered without in_first is taken (in_ready is high) and dropped, and tx_en stays low.
- R11: In_first on a byte inside a frame is treated as ordinary data and does not restart the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | 8 | Frame byte |
| in_first | input | 1 | Offered byte is the first of a frame |
| in_last | input | 1 | Offered byte is the last of a frame |
| in_ready | output | 1 | Block takes the offered byte at this edge |
| tx_en | output | 1 | Transmit enable to the PHY |
| txd | output | 2 | Transmit dibit to the PHY |

## Verification
Two events can fall in the same cycle: the end of one frame's final dibit and the arrival of the next frame's first byte. The bench provokes this by offering the next first-marked byte in the same cycle tx_en first reads low. It then requires exactly 48 quiet cycles with txd at 00 before the next rise. A second overlap is the request for a byte at the last dibit of a byte colliding with a source that is not ready. This is provoked by withholding the byte at chosen positions, and it is judged by the frame length and by the count of bytes taken.

// File: rtl/rmii_tx_pkg.sv
package rmii_tx_pkg;

  localparam int BYTE_W          = 8;
  localparam int DIBIT_W         = 2;
  localparam int DIBITS_PER_BYTE = BYTE_W / DIBIT_W;
  localparam int REM_W           = BYTE_W - DIBIT_W;

  localparam logic [BYTE_W-1:0] PRE_BYTE = 8'h55;
  localparam logic [BYTE_W-1:0] SFD_BYTE = 8'hD5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } tx_state_e;

  function automatic logic [DIBIT_W-1:0] pick_dibit(input logic [BYTE_W-1:0] b,
                                                    input logic [1:0]        pos);
    logic [DIBIT_W-1:0] d;
    case (pos)
      2'd0:    d = b[1:0];
      2'd1:    d = b[3:2];
      2'd2:    d = b[5:4];
      default: d = b[7:6];
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rmii_tx_rst_sync.sv
module rmii_tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rmii_tx_preamble_gen.sv
module rmii_tx_preamble_gen
  import rmii_tx_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int CNT_W     = 5
) (
  input  logic [CNT_W-1:0]   idx,
  output logic [DIBIT_W-1:0] dibit
);

  localparam int                 POS_W   = CNT_W - 2;
  localparam logic [POS_W-1:0]   SFD_POS = POS_W'(PRE_BYTES);

  logic [BYTE_W-1:0] cur_byte;

  always_comb begin
    if (idx[CNT_W-1:2] == SFD_POS) begin
      cur_byte = SFD_BYTE;
    end else begin
      cur_byte = PRE_BYTE;
    end
    dibit = pick_dibit(cur_byte, idx[1:0]);
  end

endmodule

// File: rtl/rmii_tx_gap_timer.sv
module rmii_tx_gap_timer #(
  parameter int GAP_DIBITS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);

  localparam int            GW       = $clog2(GAP_DIBITS);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_DIBITS - 1);

  logic [GW-1:0] cnt_q;
  logic [GW-1:0] cnt_n;
  logic          cnt_en;

  assign done = (cnt_q == GAP_LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (restart) begin
      cnt_en = 1'b1;
      cnt_n  = '0;
    end else if (!done) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= GAP_LAST;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/rmii_tx_byte_shifter.sv
module rmii_tx_byte_shifter
  import rmii_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [BYTE_W-1:0]  data_in,
  input  logic               last_in,
  output logic [DIBIT_W-1:0] dibit,
  output logic               last
);

  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] rem_n;
  logic             last_q;
  logic             last_n;
  logic             reg_en;

  always_comb begin
    reg_en = load | shift;
    rem_n  = rem_q;
    last_n = last_q;
    if (load) begin
      rem_n  = data_in[BYTE_W-1:DIBIT_W];
      last_n = last_in;
    end else if (shift) begin
      rem_n  = {{DIBIT_W{1'b0}}, rem_q[REM_W-1:DIBIT_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      last_q <= 1'b0;
    end else if (reg_en) begin
      rem_q  <= rem_n;
      last_q <= last_n;
    end
  end

  assign dibit = rem_q[DIBIT_W-1:0];
  assign last  = last_q;

endmodule

// File: rtl/rmii_tx_serializer.sv
module rmii_tx_serializer
  import rmii_tx_pkg::*;
#(
  parameter int PRE_BYTES  = 7,
  parameter int GAP_DIBITS = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_first,
  input  logic        in_last,
  output logic        in_ready,
  output logic        tx_en,
  output logic [1:0]  txd
);

  localparam int               PRE_DIBITS = (PRE_BYTES + 1) * DIBITS_PER_BYTE;
  localparam int               CNT_W      = $clog2(PRE_DIBITS);
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_DIBITS - 1);
  localparam logic [1:0]       BYTE_LAST  = 2'(DIBITS_PER_BYTE - 1);

  logic rst_n_int;

  tx_state_e          st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               en_q, en_n;
  logic [DIBIT_W-1:0] txd_q, txd_n;

  logic [CNT_W-1:0]   pre_idx;
  logic [DIBIT_W-1:0] pre_dibit;
  logic               gap_done;
  logic               gap_restart;
  logic               sh_load;
  logic               sh_shift;
  logic [DIBIT_W-1:0] sh_dibit;
  logic               sh_last;
  logic               ready_c;
  logic               finish;

  rmii_tx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rmii_tx_preamble_gen #(.PRE_BYTES(PRE_BYTES), .CNT_W(CNT_W)) u_pre (
    .idx   (pre_idx),
    .dibit (pre_dibit)
  );

  rmii_tx_gap_timer #(.GAP_DIBITS(GAP_DIBITS)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .restart (gap_restart),
    .done    (gap_done)
  );

  rmii_tx_byte_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load    (sh_load),
    .shift   (sh_shift),
    .data_in (in_data),
    .last_in (in_last),
    .dibit   (sh_dibit),
    .last    (sh_last)
  );

  // preamble index of the dibit to be presented at the next edge
  always_comb begin
    if (st_q == ST_IDLE) begin
      pre_idx = '0;
    end else begin
      pre_idx = cnt_q + 1'b1;
    end
  end

  // next-state logic
  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    en_n     = en_q;
    txd_n    = txd_q;
    ready_c  = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    finish   = 1'b0;

    case (st_q)
      ST_IDLE: begin
        // stray bytes without a start marker are drained
        ready_c = in_valid & ~in_first;
        if (in_valid && in_first && gap_done) begin
          st_n  = ST_PRE;
          cnt_n = '0;
          en_n  = 1'b1;
          txd_n = pre_dibit;
        end
      end

      ST_PRE: begin
        if (cnt_q == PRE_LAST) begin
          ready_c = 1'b1;
          if (in_valid) begin
            sh_load = 1'b1;
            st_n    = ST_DATA;
            cnt_n   = '0;
            txd_n   = in_data[DIBIT_W-1:0];
          end else begin
            finish = 1'b1;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
          txd_n = pre_dibit;
        end
      end

      ST_DATA: begin
        if (cnt_q[1:0] != BYTE_LAST) begin
          cnt_n    = cnt_q + 1'b1;
          txd_n    = sh_dibit;
          sh_shift = 1'b1;
        end else if (sh_last) begin
          finish = 1'b1;
        end else begin
          ready_c = 1'b1;
          if (in_valid) begin
            sh_load = 1'b1;
            cnt_n   = '0;
            txd_n   = in_data[DIBIT_W-1:0];
          end else begin
            finish = 1'b1;
          end
        end
      end

      default: begin
        finish = 1'b1;
      end
    endcase

    if (finish) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      en_n  = 1'b0;
      txd_n = '0;
    end
  end

  assign gap_restart = finish;

  // state registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      en_q  <= 1'b0;
      txd_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      en_q  <= en_n;
      txd_q <= txd_n;
    end
  end

  assign in_ready = ready_c;
  assign tx_en    = en_q;
  assign txd      = txd_q;

endmodule

// File: rtl/rmii_tx_checker.sv
module rmii_tx_checker #(
  parameter int GAP_DIBITS = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_first,
  input logic       in_ready,
  input logic       tx_en,
  input logic [1:0] txd
);

  logic [15:0] hi_cnt;
  logic [15:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= 16'(GAP_DIBITS);
    end else begin
      if (tx_en) begin
        hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1;
        lo_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        lo_cnt <= (lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1;
      end
    end
  end

  p_txd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd == 2'b00);

  p_rise_dibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> txd == 2'b01);

  p_ready_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && in_ready) |-> hi_cnt[1:0] == 2'd3);

  p_frame_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> (hi_cnt[1:0] == 2'd0 && hi_cnt >= 16'd32));

  p_gap_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> lo_cnt >= 16'(GAP_DIBITS));

  p_discard_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && in_ready) |-> (in_valid && !in_first));

endmodule

bind rmii_tx_serializer rmii_tx_checker #(.GAP_DIBITS(GAP_DIBITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_first (in_first),
  .in_ready (in_ready),
  .tx_en    (tx_en),
  .txd      (txd)
);

// File: tb/sim_rmii_tx_serializer.sv
module sim_rmii_tx_serializer;

  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_first;
  logic       in_last;
  logic       in_ready;
  logic       tx_en;
  logic [1:0] txd;

  int n_chk;
  int n_bad;
  bit finished;

  rmii_tx_serializer u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_first (in_first),
    .in_last  (in_last),
    .in_ready (in_ready),
    .tx_en    (tx_en),
    .txd      (txd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_val(input int fid, input int i);
    return 8'(fid * 53 + i * 29 + 7);
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0;
    in_data  = 8'h00;
    in_first = 1'b0;
    in_last  = 1'b0;
  endtask

  // drives one frame and judges it; stall = byte index withheld (-1 none),
  // first_at = extra byte index carrying in_first (-1 none)
  task automatic run_frame(input int fid, input int len, input int stall,
                           input int first_at, input bit b2b);
    logic [1:0] got [0:1023];
    int  bi = 0;
    int  ndib = 0;
    int  lows = 0;
    int  readies = 0;
    int  exp_n;
    int  bad_at;
    bit  seen = 1'b0;
    bit  phase_ok = 1'b1;
    bit  idle_ok = 1'b1;
    bit  ended = 1'b0;
    logic [1:0] e;
    exp_n = (stall >= 0 && stall < len) ? stall : len;
    for (int guard = 0; guard < 1000; guard++) begin
      if (tx_en) begin
        seen = 1'b1;
        got[ndib] = txd;
        ndib++;
      end else if (seen) begin
        ended = 1'b1;
        break;
      end else begin
        lows++;
        if (txd != 2'b00) idle_ok = 1'b0;
      end
      if (bi < len && bi != stall) begin
        in_valid = 1'b1;
        in_data  = byte_val(fid, bi);
        in_first = (bi == 0) || (bi == first_at);
        in_last  = (bi == len - 1);
      end else begin
        idle_inputs();
      end
      #1;
      if (in_ready) begin
        if (tx_en) begin
          readies++;
          if (((ndib - 1) % 4) != 3) phase_ok = 1'b0;
          if (in_valid) bi++;
        end else begin
          phase_ok = 1'b0;
        end
      end
      step();
    end
    idle_inputs();
    chk(ended, "R7 frame ended", ended, 1);
    // R3 / R9: quiet cycles before the rise
    if (b2b) chk(lows == 48, "R9 gap", lows, 48);
    else     chk(lows == 1, "R3 start latency", lows, 1);
    chk(idle_ok, "R2 txd idle", idle_ok, 1);
    chk(ndib == 32 + 4 * exp_n, "R7 frame length", ndib, 32 + 4 * exp_n);
    bad_at = -1;
    for (int k = 0; k < 32; k++) begin
      e = (k == 31) ? 2'b11 : 2'b01;
      if (bad_at < 0 && got[k] != e) bad_at = k;
    end
    chk(bad_at < 0, "R4 preamble", bad_at, -1);
    bad_at = -1;
    for (int k = 0; k < 4 * exp_n && 32 + k < ndib; k++) begin
      e = 2'((byte_val(fid, k / 4) >> (2 * (k % 4))) & 8'h03);
      if (bad_at < 0 && got[32 + k] != e) bad_at = k;
    end
    if (first_at >= 0) chk(bad_at < 0, "R11 mid first as data", bad_at, -1);
    else               chk(bad_at < 0, "R5 payload dibits", bad_at, -1);
    chk(phase_ok, "R6 ready phase", phase_ok, 1);
    chk(readies == exp_n + ((stall >= 0 && stall < len) ? 1 : 0), "R6 ready count",
        readies, exp_n + ((stall >= 0 && stall < len) ? 1 : 0));
    if (stall >= 0) chk(bi == exp_n, "R8 bytes taken on underrun", bi, exp_n);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    idle_inputs();
    repeat (4) @(posedge clk);
    #2;
    // R1: outputs quiet during reset
    chk(tx_en == 1'b0 && txd == 2'b00 && in_ready == 1'b0, "R1 in reset",
        {tx_en, txd, in_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    chk(tx_en == 1'b0 && txd == 2'b00 && in_ready == 1'b0, "R1 after reset",
        {tx_en, txd, in_ready}, 0);

    run_frame(0, 3, -1, -1, 1'b0);
    for (int len = 1; len <= 12; len++) begin
      run_frame(len, len, -1, -1, 1'b1);
    end
    for (int s = 1; s <= 3; s++) begin
      run_frame(20 + s, 6, s, -1, 1'b1);
    end
    run_frame(30, 5, -1, 2, 1'b1);

    // R2: long idle stays quiet
    for (int i = 0; i < 60; i++) begin
      step();
      if (i % 20 == 0) chk(tx_en == 1'b0 && txd == 2'b00, "R2 idle", {tx_en, txd}, 0);
    end

    // R10: unmarked bytes while idle are drained and never sent
    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1;
      in_data  = 8'hA0 + 8'(i);
      in_first = 1'b0;
      in_last  = (i == 4);
      #1;
      chk(in_ready == 1'b1, "R10 drain ready", in_ready, 1);
      step();
      chk(tx_en == 1'b0 && txd == 2'b00, "R10 no transmit", {tx_en, txd}, 0);
    end
    idle_inputs();
    for (int i = 0; i < 10; i++) begin
      step();
    end
    chk(tx_en == 1'b0, "R10 still quiet", tx_en, 0);
    run_frame(40, 4, -1, -1, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule